// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus side of a byte-wide non-volatile store reached over a two-wire serial bus. It reads SCL and SDA from open-drain pads and pulls SDA low through `sda_oe` whenever it acknowledges or sends a 0 bit. The address byte that follows a start selects the device. That byte must carry the fixed family code and three bits that equal the board straps. After the address byte, a write carries a 16-bit word address followed by data bytes. The data bytes collect in a page buffer. A stop then commits them during a self-timed write cycle.

While that cycle runs, the slave ignores the bus. A host finds out that the cycle is over by sending address bytes until one of them is acknowledged. A read returns bytes from the current address and advances the address after each byte. A random read is built from a write that carries only the word address, followed by a repeated start with the read bit set. The array has 2^MEM_AW bytes and is indexed by the low bits of the 16-bit word address. A page holds 2^PAGE_W bytes, and TWR_CLKS is the length of the write cycle in system clocks.

Top module: `twi_mem_slave`

## Requirements
- R1: The first byte after a start is accepted only when bits 7..4 are 1010 and bits 3..1 equal `strap[2:0]`. Any other value gets no acknowledge, and all further bus activity is ignored until the next start.
- R2: Any of the eight strap values selects the device, so two different strap settings answer to two different address bytes.
- R3: Bit 0 of the address byte chooses the direction: 0 means write and 1 means read.
- R4: The slave acknowledges by holding SDA low during the ninth clock. It does so for a matching address byte, for both word address bytes and for every data byte it receives. Outside an acknowledge or a 0 data bit, it never drives SDA.
- R5: In a write, the two bytes after the address byte form the word address, high byte first. The first data byte is stored at that address.
- R6: After each data byte, the low PAGE_W address bits increase by one and wrap within the page, while the upper bits stay fixed. A byte sent after the page is full overwrites the earlier byte at that position.
- R7: A stop after at least one complete data byte starts a write cycle of TWR_CLKS clocks. During the cycle, nothing on the bus is acknowledged.
- R8: Once the write cycle is over, an address byte is acknowledged again and the new transaction proceeds normally.
- R9: While `wp` is high at the stop, bytes are still acknowledged, but the array keeps its contents and no write cycle starts.
- R10: A start or stop that arrives inside a byte discards every uncommitted data byte of the transaction and starts no write cycle.
- R11: A read sends the byte at the current address MSB first and then adds one to the whole 16-bit address. Sequential reads therefore run across page boundaries.
- R12: When the host answers a read byte with a NACK, the slave releases SDA and drives nothing more until the next start.
- R13: A write that ends after the word address, with no data byte, starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock from the pad |
| sda_i | input | 1 | Serial data from the pad |
| strap | input | 3 | Hardwired device-select bits |
| wp | input | 1 | Write-protect; high keeps the array unchanged |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
Some properties are checked by assertions on every cycle:
- SDA is never driven during a write cycle.
- The drive turns on only while SCL is low.
- A write cycle begins only from the data phase of a write, and only with write-protect low.

Other behaviour only shows up through the bench's bus transactions: address matching, page wrap, what ends up in the array after protected or aborted writes, the point at which acknowledge polling succeeds, and the order of the read-back data.

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int MEM_AW   = 11,
  parameter int PAGE_W   = 7,
  parameter int TWR_CLKS = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       sda_oe
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int CW   = $clog2(TWR_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT, S_RDAT, S_BUSY} st_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  wire        scl_s = scl_q[1];
  wire        sda_s = sda_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i}; sda_q <= {sda_q[0], sda_i};
      scl_d <= scl_s; sda_d <= sda_s;
    end

  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  st_t             st;
  logic [3:0]      bitcnt;
  logic            in_ack;
  logic [7:0]      shreg, tx;
  logic [15:0]     addr;
  logic [PAGE-1:0] pval;
  logic [CW-1:0]   wcnt;
  logic [7:0]      pbuf [PAGE];
  logic [7:0]      mem  [2**MEM_AW];

  wire [7:0]        rd       = mem[addr[MEM_AW-1:0]];
  wire [PAGE_W-1:0] cm_i     = wcnt[PAGE_W-1:0];
  wire              cm_en    = (st == S_BUSY) && (32'(wcnt) < PAGE) && pval[cm_i];
  wire              rx_st    = (st == S_DEV) || (st == S_AHI) || (st == S_ALO) || (st == S_WDAT);
  wire              byte_done = rx_st && scl_fall && !in_ack && (bitcnt == 4'd8) && !start_c && !stop_c;
  wire              commit_ok = (st == S_WDAT) && (pval != '0) && !in_ack && (bitcnt <= 4'd1) && !wp;

  always_ff @(posedge clk) begin
    if (byte_done && st == S_WDAT) pbuf[addr[PAGE_W-1:0]] <= shreg;
    if (cm_en) mem[{addr[MEM_AW-1:PAGE_W], cm_i}] <= pbuf[cm_i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; in_ack <= 1'b0; shreg <= '0; tx <= '0;
      addr <= '0; pval <= '0; wcnt <= '0; sda_oe <= 1'b0;
    end else if (st == S_BUSY) begin
      wcnt <= wcnt + 1'b1;
      if (32'(wcnt) == TWR_CLKS - 1) begin
        st <= S_IDLE; pval <= '0;
      end
    end else if (start_c) begin
      st <= S_DEV; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0; pval <= '0;
    end else if (stop_c) begin
      sda_oe <= 1'b0; in_ack <= 1'b0; bitcnt <= '0;
      if (commit_ok) begin
        st <= S_BUSY; wcnt <= '0;
      end else begin
        st <= S_IDLE; pval <= '0;
      end
    end else if (st == S_RDAT) begin
      if (scl_rise && !in_ack) begin
        if (bitcnt == 4'd8) begin
          addr <= addr + 16'd1;
          if (sda_s) st <= S_IDLE;
          else bitcnt <= 4'd9;
        end else if (bitcnt < 4'd8) bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall) begin
        if (in_ack || bitcnt == 4'd9) begin
          in_ack <= 1'b0; tx <= rd; sda_oe <= ~rd[7]; bitcnt <= '0;
        end else if (bitcnt == 4'd8) sda_oe <= 1'b0;
        else if (bitcnt != 4'd0) begin
          sda_oe <= ~tx[6]; tx <= {tx[6:0], 1'b0};
        end
      end
    end else if (rx_st) begin
      if (scl_rise && !in_ack && bitcnt < 4'd8) begin
        shreg <= {shreg[6:0], sda_s}; bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall && in_ack) begin
        in_ack <= 1'b0; sda_oe <= 1'b0; bitcnt <= '0;
      end else if (byte_done) begin
        in_ack <= 1'b1; sda_oe <= 1'b1; bitcnt <= '0;
        case (st)
          S_DEV:
            if (shreg[7:1] == {4'b1010, strap}) st <= shreg[0] ? S_RDAT : S_AHI;
            else begin
              st <= S_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0;
            end
          S_AHI: begin addr[15:8] <= shreg; st <= S_ALO; end
          S_ALO: begin addr[7:0]  <= shreg; st <= S_WDAT; end
          default: begin
            pval[addr[PAGE_W-1:0]] <= 1'b1;
            addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
          end
        endcase
      end
    end

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (st == S_BUSY) |-> !sda_oe); // R7
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_s); // R4
  AST_CYCLE_WP_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(st == S_BUSY) |-> !$past(wp)); // R9
  AST_CYCLE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n) $rose(st == S_BUSY) |-> $past(st) == S_WDAT); // R13
endmodule

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;
  localparam int TWR = 600;

  logic clk = 1'b0, rst_n = 1'b0, scl_h = 1'b1, sda_h = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b000;
  logic sda_oe;
  wire  sda_bus = sda_h & ~sda_oe;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_mem_slave #(.MEM_AW(10), .PAGE_W(3), .TWR_CLKS(TWR)) i_twi_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
    .strap(strap), .wp(wp), .sda_oe(sda_oe));

  localparam logic [23:0] VEC [6] = '{24'h0010A5, 24'h00503C, 24'h006011,
                                      24'h03FF7E, 24'h0108C3, 24'h020000};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bstart;
    sda_h = 1'b1; w(HP); scl_h = 1'b1; w(HP); sda_h = 1'b0; w(HP); scl_h = 1'b0; w(HP);
  endtask

  task automatic bstop;
    sda_h = 1'b0; w(HP); scl_h = 1'b1; w(HP); sda_h = 1'b1; w(HP);
  endtask

  task automatic bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sda_h = v[7-i]; w(HP); scl_h = 1'b1; w(HP); scl_h = 1'b0; w(2);
    end
  endtask

  task automatic sbyte(input logic [7:0] v, output bit ack);
    bits(v, 8);
    sda_h = 1'b1; w(HP); scl_h = 1'b1; w(HP); ack = !sda_bus; scl_h = 1'b0; w(HP);
  endtask

  task automatic rbyte(input bit nack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(HP); scl_h = 1'b1; w(HP); b = {b[6:0], sda_bus}; scl_h = 1'b0; w(2);
    end
    sda_h = nack; w(HP); scl_h = 1'b1; w(HP); scl_h = 1'b0; w(2); sda_h = 1'b1; w(HP);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic poll_now(output bit ack);
    bstart; sbyte(dev(strap, 1'b0), ack); bstop;
  endtask

  task automatic wait_ready(output int polls);
    bit a;
    polls = 0;
    do begin poll_now(a); polls++; end while (!a && polls < 40);
  endtask

  task automatic set_addr(input logic [15:0] a, output bit ok);
    bit a0, a1, a2;
    bstart; sbyte(dev(strap, 1'b0), a0); sbyte(a[15:8], a1); sbyte(a[7:0], a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_at(input logic [15:0] a, output logic [7:0] d);
    bit ok, a3;
    set_addr(a, ok);
    bstart; sbyte(dev(strap, 1'b1), a3);
    rbyte(1'b1, d); bstop;
    chk(ok && a3, "R3 read setup acks", {ok, a3}, 2'b11);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit ok, a, a2;
    int polls;
    logic [7:0] d;
    logic [7:0] exp_pg [8];
    w(5);
    chk(sda_oe == 1'b0, "R4 reset releases SDA", sda_oe, 0);
    rst_n = 1'b1; w(5);
    chk(sda_oe == 1'b0, "R4 idle after reset", sda_oe, 0);

    foreach (VEC[k]) begin
      set_addr(VEC[k][23:8], ok);
      sbyte(VEC[k][7:0], a); bstop;
      chk(ok && a, "R4 R5 write acks", {ok, a}, 2'b11);
      poll_now(a);
      chk(!a, "R7 no ack during write cycle", a, 0);
      wait_ready(polls);
      chk(polls < 40, "R8 ack polling succeeds", polls, 1);
      rd_at(VEC[k][23:8], d);
      chk(d == VEC[k][7:0], "R5 R11 readback", d, VEC[k][7:0]);
    end

    bstart; sbyte({4'b1011, strap, 1'b0}, a); bstop;
    chk(!a, "R1 wrong family code", a, 0);
    bstart; sbyte(dev(3'b001, 1'b0), a); sbyte(dev(strap, 1'b0), a2); bstop;
    chk(!a && !a2, "R1 strap mismatch then idle", {a, a2}, 0);
    strap = 3'b101;
    bstart; sbyte(dev(3'b000, 1'b0), a); bstop;
    bstart; sbyte(dev(3'b101, 1'b0), a2); bstop;
    chk(!a && a2, "R2 strap selects device", {a, a2}, 2'b01);

    set_addr(16'h0010, ok); bstop;
    poll_now(a);
    chk(ok && a, "R13 address-only write starts no cycle", {ok, a}, 2'b11);

    wp = 1'b1;
    set_addr(16'h0050, ok); sbyte(8'hEE, a); bstop;
    chk(ok && a, "R9 protected bytes acked", {ok, a}, 2'b11);
    poll_now(a);
    chk(a, "R9 no cycle while protected", a, 1);
    wp = 1'b0;
    rd_at(16'h0050, d);
    chk(d == 8'h3C, "R9 array unchanged", d, 8'h3C);

    set_addr(16'h0060, ok); sbyte(8'h99, a); bits(8'h55, 4); bstop;
    poll_now(a2);
    chk(a && a2, "R10 stop mid-byte: no cycle", {a, a2}, 2'b11);
    set_addr(16'h0060, ok); sbyte(8'h77, a); bits(8'h55, 3);
    bstart; sbyte(dev(strap, 1'b0), a2); bstop;
    chk(a && a2, "R10 start mid-byte accepted at once", {a, a2}, 2'b11);
    rd_at(16'h0060, d);
    chk(d == 8'h11, "R10 aborted bytes discarded", d, 8'h11);

    set_addr(16'h0106, ok);
    for (int i = 0; i < 9; i++) sbyte(8'hD0 + 8'(i), a);
    bstop; wait_ready(polls);
    for (int i = 0; i < 9; i++) exp_pg[(6 + i) % 8] = 8'hD0 + 8'(i);
    set_addr(16'h0100, ok); bstart; sbyte(dev(strap, 1'b1), a);
    for (int i = 0; i < 8; i++) begin
      rbyte(1'b0, d);
      chk(d == exp_pg[i], "R6 page wrap contents", d, exp_pg[i]);
    end
    rbyte(1'b1, d);
    chk(d == 8'hC3, "R11 sequential read crosses page", d, 8'hC3);
    chk(sda_oe == 1'b0, "R12 released after NACK", sda_oe, 0);
    bits(8'h00, 1); sda_h = 1'b1; w(HP); scl_h = 1'b1; w(HP);
    chk(sda_bus == 1'b1, "R12 no drive after NACK", sda_bus, 1);
    scl_h = 1'b0; w(HP); bstop;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule